// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status

This block turns an asynchronous serial line into bytes. A one-cycle enable pulse at sixteen times the bit rate drives all timing. A falling line in idle starts a frame. The block samples the start bit again at its midpoint, then takes each following bit once per sixteen ticks at mid-bit. Word length, parity mode and stop-bit count come from line-control inputs, which are held steady while a frame is arriving. The serial input must already be synchronous to the clock.

Each completed character goes into a sixteen-entry queue together with its own parity, framing and break flags. The host sees the oldest character and its flags at the status outputs. It removes the character with a read strobe. A status-read strobe acknowledges the error flags of the character at the head, and it clears the sticky overrun flag.

Top module: `serial_rx_status`

## Requirements
- R1: `wlen` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits. Data arrives least significant bit first. Bits above the word length read as 0 in `rx_data`.
- R2: A low line seen on a tick in idle is sampled again eight ticks later. If it is high there, the event is dropped and no character is produced.
- R3: The queue holds 16 characters in arrival order. `st_ready` is 1 whenever at least one is held. `rx_data` shows the oldest character (0 when empty), and `rd_data` removes it.
- R4: When a character completes while the queue already holds 16, that character is discarded, the stored ones are kept, and `st_overrun` goes to 1. `st_overrun` stays at 1 until a cycle with `rd_lsr` that has no new overrun. If an overrun and `rd_lsr` fall in the same cycle, the flag ends up set.
- R5: With `par_en`=1, one parity bit follows the data. With `par_stick`=0, `par_even`=1 expects an even count of ones over data plus parity, and `par_even`=0 expects an odd count. With `par_stick`=1, the parity bit must equal the inverse of `par_even`. A mismatch marks the character's parity error. With `par_en`=0, no parity bit is taken.
- R6: A 0 sampled in the stop position marks a framing error. With `two_stop`=1, a second stop bit is also checked.
- R7: A frame whose every sample is 0, start through the last stop, is stored as 0x00 with break and framing flags set. No new start is searched for until the line has returned high.
- R8: `st_parity`, `st_framing` and `st_break` show the flags of the head character. After `rd_lsr` they read 0 until the head changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial line, idle high, synchronous to clk |
| tick16 | input | 1 | Enable pulse at 16x bit rate |
| wlen | input | 2 | Data bits: 0..3 give 5..8 |
| two_stop | input | 1 | Check a second stop bit |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select, or inverse stick value |
| par_stick | input | 1 | Fixed-value parity |
| rd_data | input | 1 | Remove head character |
| rd_lsr | input | 1 | Status read: acknowledge head flags, clear overrun |
| rx_data | output | 8 | Head character |
| st_ready | output | 1 | At least one character held |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity | output | 1 | Head parity error |
| st_framing | output | 1 | Head framing error |
| st_break | output | 1 | Head break indication |

## Verification
An overrun event and a status read can land on the same clock edge. That edge is the one where the stop bit of a seventeenth character is sampled into an already full queue. The bench fills the queue, then pulses `rd_lsr` for exactly the cycle eight ticks into that character's stop bit. It then expects `st_overrun` still set, and cleared only by a later lone status read. It also pops all sixteen stored characters to show the extra one was dropped.

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic [1:0] wlen,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rd_data,
  input  logic       rd_lsr,
  output logic [7:0] rx_data,
  output logic       st_ready,
  output logic       st_overrun,
  output logic       st_parity,
  output logic       st_framing,
  output logic       st_break
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int EW = 11;
  localparam logic [DEPTH_LOG2:0] FULLV = (DEPTH_LOG2+1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_HOLD} st_t;
  st_t st;
  logic [3:0] tcnt, bidx;
  logic [7:0] sh;
  logic pe_acc, stop_bad, zeros;

  wire [3:0] dlen    = 4'd5 + {2'b00, wlen};
  wire [3:0] last    = dlen + {3'b000, par_en} + {3'b000, two_stop};
  wire       mid     = tick16 && (tcnt == 4'd15);
  wire       in_data = bidx < dlen;
  wire       in_par  = par_en && (bidx == dlen);
  wire       exp_par = par_stick ? ~par_even : (^sh ^ ~par_even);
  wire       done    = (st == S_BITS) && mid && (bidx == last);
  wire       zero_n  = zeros & ~rx_in;
  wire       fe_n    = stop_bad | ~rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0;
      pe_acc <= 1'b0; stop_bad <= 1'b0; zeros <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (tick16 && !rx_in) begin st <= S_START; tcnt <= '0; end
        S_START: if (tick16) begin
          if (tcnt == 4'd7) begin
            if (rx_in) st <= S_IDLE;
            else begin
              st <= S_BITS; tcnt <= '0; bidx <= '0; sh <= '0;
              pe_acc <= 1'b0; stop_bad <= 1'b0; zeros <= 1'b1;
            end
          end else tcnt <= tcnt + 4'd1;
        end
        S_BITS: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (mid) begin
            if (in_data) sh[bidx[2:0]] <= rx_in;
            if (in_par) pe_acc <= rx_in ^ exp_par;
            if (!in_data && !in_par) stop_bad <= stop_bad | ~rx_in;
            zeros <= zeros & ~rx_in;
            bidx <= bidx + 4'd1;
            if (done) st <= zero_n ? S_HOLD : S_IDLE;
          end
        end
        default: if (rx_in) st <= S_IDLE;
      endcase
    end
  end

  logic [EW-1:0] mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wptr, rptr;
  logic [DEPTH_LOG2:0] cnt;
  logic head_ack;

  wire full  = cnt == FULLV;
  wire empty = cnt == '0;
  wire push  = done && !full;
  wire pop   = rd_data && !empty;
  wire [EW-1:0] head = mem[rptr];

  always_ff @(posedge clk) if (push) mem[wptr] <= {zero_n, fe_n, par_en & pe_acc, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0; head_ack <= 1'b0; st_overrun <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (pop) head_ack <= 1'b0;
      else if (rd_lsr && !empty) head_ack <= 1'b1;
      if (done && full) st_overrun <= 1'b1;
      else if (rd_lsr) st_overrun <= 1'b0;
    end
  end

  assign st_ready   = !empty;
  assign rx_data    = empty ? 8'h00 : head[7:0];
  assign st_parity  = !empty && !head_ack && head[8];
  assign st_framing = !empty && !head_ack && head[9];
  assign st_break   = !empty && !head_ack && head[10];
endmodule

module serial_rx_status_chk #(
  parameter int DEPTH_LOG2 = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_data,
  input logic                rd_lsr,
  input logic [7:0]          rx_data,
  input logic                st_ready,
  input logic                st_overrun,
  input logic                st_parity,
  input logic                st_framing,
  input logic                st_break,
  input logic [DEPTH_LOG2:0] cnt,
  input logic                done,
  input logic                full
);
  localparam logic [DEPTH_LOG2:0] FULLV = (DEPTH_LOG2+1)'(1 << DEPTH_LOG2);

  AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_ready) |-> $past(rd_data)); // R3
  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(cnt) == FULLV); // R4
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !rd_data) |=> cnt == FULLV); // R4
  AST_FLAG_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !rd_data && st_ready) |=> (!st_parity && !st_framing && !st_break)); // R8
  AST_BREAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    st_break |-> (st_framing && rx_data == 8'h00)); // R7
endmodule

bind serial_rx_status serial_rx_status_chk #(.DEPTH_LOG2(DEPTH_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_lsr(rd_lsr), .rx_data(rx_data),
  .st_ready(st_ready), .st_overrun(st_overrun), .st_parity(st_parity),
  .st_framing(st_framing), .st_break(st_break), .cnt(cnt), .done(done), .full(full)
);

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, tick16 = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic two_stop = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic rd_data = 1'b0, rd_lsr = 1'b0;
  logic [7:0] rx_data;
  logic st_ready, st_overrun, st_parity, st_framing, st_break;
  int total = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_status dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16), .wlen(wlen),
    .two_stop(two_stop), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rd_data(rd_data), .rd_lsr(rd_lsr), .rx_data(rx_data), .st_ready(st_ready),
    .st_overrun(st_overrun), .st_parity(st_parity), .st_framing(st_framing),
    .st_break(st_break)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int dl, input bit hp, input bit pb,
                      input bit s1, input bit hs2, input bit s2, input int lsr_at);
    logic [12:0] b;
    int n;
    b = '0; n = 0;
    b[n++] = 1'b0;
    for (int i = 0; i < dl; i++) b[n++] = d[i];
    if (hp) b[n++] = pb;
    b[n++] = s1;
    if (hs2) b[n++] = s2;
    for (int j = 0; j < n; j++) begin
      rx_in = b[j];
      for (int c = 0; c < 16; c++) begin
        rd_lsr = (j == lsr_at && c == 8);
        @(negedge clk);
      end
    end
    rd_lsr = 1'b0;
    rx_in = 1'b1;
    idle(4);
  endtask

  task automatic pulse_pop();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_lsr();
    rd_lsr = 1'b1; @(negedge clk); rd_lsr = 1'b0;
  endtask

  task automatic head_is(input string req, input logic [7:0] d, input bit pe, input bit fe, input bit bi);
    chk(st_ready, req, "ready", st_ready, 1);
    chk(rx_data == d, req, "data", rx_data, d);
    chk(st_parity == pe, req, "parity flag", st_parity, pe);
    chk(st_framing == fe, req, "framing flag", st_framing, fe);
    chk(st_break == bi, req, "break flag", st_break, bi);
  endtask

  task automatic t_reset();
    chk(!st_ready && rx_data == 8'h00, "R3", "reset ready/data", {st_ready, rx_data}, 0);
    chk({st_overrun, st_parity, st_framing, st_break} == 4'b0, "R4", "reset flags",
        {st_overrun, st_parity, st_framing, st_break}, 0);
  endtask

  task automatic t_word_lengths();
    par_en = 1'b0; two_stop = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] m;
      wlen = 2'(k);
      m = 8'hFF >> (3 - k);
      send(8'hDB, 5 + k, 0, 0, 1, 0, 0, -1);
      head_is("R1", 8'hDB & m, 0, 0, 0);
      pulse_pop();
    end
    wlen = 2'd3;
  endtask

  task automatic t_glitch();
    rx_in = 1'b0; idle(4); rx_in = 1'b1; idle(40);
    chk(!st_ready, "R2", "glitch produced character", st_ready, 0);
    send(8'h3C, 8, 0, 0, 1, 0, 0, -1);
    head_is("R2", 8'h3C, 0, 0, 0);
    pulse_pop();
  endtask

  task automatic t_parity();
    // 0x35 has four ones
    par_en = 1'b1; par_stick = 1'b0; par_even = 1'b1;
    send(8'h35, 8, 1, 0, 1, 0, 0, -1); head_is("R5", 8'h35, 0, 0, 0); pulse_pop();
    send(8'h35, 8, 1, 1, 1, 0, 0, -1); head_is("R5", 8'h35, 1, 0, 0); pulse_pop();
    par_even = 1'b0;
    send(8'h35, 8, 1, 1, 1, 0, 0, -1); head_is("R5", 8'h35, 0, 0, 0); pulse_pop();
    send(8'h35, 8, 1, 0, 1, 0, 0, -1); head_is("R5", 8'h35, 1, 0, 0); pulse_pop();
    par_stick = 1'b1; par_even = 1'b0;
    send(8'h34, 8, 1, 1, 1, 0, 0, -1); head_is("R5", 8'h34, 0, 0, 0); pulse_pop();
    send(8'h34, 8, 1, 0, 1, 0, 0, -1); head_is("R5", 8'h34, 1, 0, 0); pulse_pop();
    par_even = 1'b1;
    send(8'h34, 8, 1, 0, 1, 0, 0, -1); head_is("R5", 8'h34, 0, 0, 0); pulse_pop();
    send(8'h34, 8, 1, 1, 1, 0, 0, -1); head_is("R5", 8'h34, 1, 0, 0); pulse_pop();
    par_en = 1'b0; par_stick = 1'b0;
  endtask

  task automatic t_framing();
    send(8'h81, 8, 0, 0, 0, 0, 0, -1); head_is("R6", 8'h81, 0, 1, 0); pulse_pop();
    two_stop = 1'b1;
    send(8'h81, 8, 0, 0, 1, 1, 0, -1); head_is("R6", 8'h81, 0, 1, 0); pulse_pop();
    send(8'h81, 8, 0, 0, 1, 1, 1, -1); head_is("R6", 8'h81, 0, 0, 0); pulse_pop();
    two_stop = 1'b0;
  endtask

  task automatic t_break();
    rx_in = 1'b0; idle(16 * 10 + 60); rx_in = 1'b1; idle(20);
    head_is("R7", 8'h00, 0, 1, 1);
    pulse_pop();
    chk(!st_ready, "R7", "extra break characters", st_ready, 0);
    send(8'h5A, 8, 0, 0, 1, 0, 0, -1); head_is("R7", 8'h5A, 0, 0, 0); pulse_pop();
  endtask

  task automatic t_head_flags();
    par_en = 1'b1; par_even = 1'b1;
    send(8'h11, 8, 1, 0, 1, 0, 0, -1);
    send(8'h11, 8, 1, 1, 1, 0, 0, -1);
    head_is("R8", 8'h11, 0, 0, 0);
    pulse_pop();
    head_is("R8", 8'h11, 1, 0, 0);
    pulse_lsr();
    chk(st_ready && !st_parity, "R8", "flag after status read", st_parity, 0);
    pulse_pop();
    par_en = 1'b0;
  endtask

  task automatic t_fifo_overrun();
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 3), 8, 0, 0, 1, 0, 0, -1);
    chk(!st_overrun, "R4", "overrun before 17th", st_overrun, 0);
    send(8'hEE, 8, 0, 0, 1, 0, 0, 9);
    chk(st_overrun, "R4", "overrun with same-cycle status read", st_overrun, 1);
    pulse_lsr();
    chk(!st_overrun, "R4", "overrun after status read", st_overrun, 0);
    for (int i = 0; i < 16; i++) begin
      chk(st_ready && rx_data == 8'(i * 7 + 3), "R3", "queue order", rx_data, 8'(i * 7 + 3));
      pulse_pop();
    end
    chk(!st_ready, "R4", "dropped character absent", st_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_word_lengths();
    t_glitch();
    t_parity();
    t_framing();
    t_break();
    t_head_flags();
    t_fifo_overrun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule